// File: doc/BRIEF.md
# Retention Power-Gating Sequencer

This controller drives the three control lines of a power domain whose flip-flops keep their state in a slave latch on an always-on rail, while the master latch sits on a switchable rail. It produces a domain clock enable, a retention enable and a supply-switch enable. It changes them one at a time, in a fixed order, so the retained state is never exposed to a clock edge or to a collapsing rail.

A sleep request taken while the domain is running gates the clock, then asserts retention, then opens the supply switch. A wake request taken while asleep closes the switch first and waits for a power-good acknowledge. It then releases retention, and re-enables the clock last. Each step is held for a programmable number of settle cycles before the next control line moves. If power-good does not arrive within a programmable window, the controller reopens the switch, keeps retention asserted, returns to the asleep mode and raises an error flag. A wake request that arrives while the domain is powering down is remembered and served as soon as the domain is fully off.

Top module: `rpg_seq`

## Requirements
- R1: During and after reset, with no request, clk_en_o=1, ret_en_o=0, pwr_sw_en_o=1, busy_o=0, done_o=0, pg_err_o=0 and mode_o=0.
- R2: A sleep_req_i seen while mode_o=0 drops clk_en_o at the next clock edge. ret_en_o rises SETTLE_CYC cycles later, and pwr_sw_en_o falls SETTLE_CYC cycles after that. SETTLE_CYC cycles after that, mode_o becomes 2.
- R3: A wake request served while mode_o=2 raises pwr_sw_en_o at the next edge. ret_en_o falls at the first edge where the switch has been on for at least SETTLE_CYC cycles and pwr_good_i was high in the cycle before. clk_en_o rises SETTLE_CYC cycles after that, and SETTLE_CYC cycles after that, mode_o returns to 0.
- R4: clk_en_o is never high while ret_en_o is high.
- R5: pwr_sw_en_o is low only while ret_en_o is high and clk_en_o is low.
- R6: At most one of clk_en_o, ret_en_o and pwr_sw_en_o changes at any clock edge.
- R7: If pwr_good_i stays low for PG_TIMEOUT cycles after the switch turns on, pwr_sw_en_o falls, ret_en_o stays high, mode_o returns to 2, pg_err_o is set and no done pulse is given. pg_err_o is cleared when the next sleep or wake request is accepted.
- R8: A wake_req_i seen while mode_o=1 is held. The wake-up sequence then starts at the edge after mode_o reaches 2, without a new request.
- R9: sleep_req_i is ignored unless mode_o=0, and wake_req_i is ignored while mode_o is 0 or 3. The outputs then follow only the sequence already in progress.
- R10: busy_o is high exactly while mode_o is 1 or 3. done_o is a single-cycle pulse in the first cycle after a sleep or wake sequence completes, and busy_o is low in that cycle.
- R11: mode_o encodes 0 = running, 1 = powering down, 2 = asleep, 3 = waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Request to power the domain down |
| wake_req_i | input | 1 | Request to power the domain up |
| pwr_good_i | input | 1 | Switch network reports the rail is up |
| clk_en_o | output | 1 | Domain clock enable |
| ret_en_o | output | 1 | Retention enable to the slave latches |
| pwr_sw_en_o | output | 1 | Supply switch enable for the master latches |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mode_o | output | 2 | Current mode (see R11) |
| pg_err_o | output | 1 | Power-good did not arrive within the window |

## Verification
The hardest situations to reach are the power-good timeout and a wake request held over from the power-down phase. The timeout needs pwr_good_i held low for the whole window. A held wake needs a wake pulse placed in the few cycles between clock gating and the supply cut. The stimulus runs in segments. Each segment draws a power-good bias, and one bias keeps the acknowledge low for the entire segment so timeouts recur. Directed cases also place a wake pulse right after the clock is gated and a sleep pulse while asleep. A cycle-accurate reference model in the bench predicts every output on every cycle.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_GATE    = 3'd1,
        ST_RETAIN  = 3'd2,
        ST_CUT     = 3'd3,
        ST_ASLEEP  = 3'd4,
        ST_RESTORE = 3'd5,
        ST_RELEASE = 3'd6,
        ST_UNGATE  = 3'd7
    } rpg_state_e;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_ASLEEP = 2'd2,
        MODE_UP     = 2'd3
    } rpg_mode_e;

    typedef struct packed {
        rpg_state_e st;
        logic       wake_pend;
        logic       pg_err;
        logic       done;
    } rpg_regs_t;

endpackage

// File: rtl/rpg_step_timer.sv
module rpg_step_timer #(
    parameter int LIMIT = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic expired_o
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    assign expired_o = (cnt_q == LAST);

    always_comb begin
        if (restart_i) begin
            cnt_d = '0;
        end else if (expired_o) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/rpg_ctrl_decode.sv
module rpg_ctrl_decode
    import rpg_pkg::*;
(
    input  rpg_state_e state_i,
    output logic       clk_en_o,
    output logic       ret_en_o,
    output logic       sw_en_o,
    output logic       busy_o,
    output rpg_mode_e  mode_o
);
    always_comb begin
        clk_en_o = (state_i == ST_RUN) || (state_i == ST_UNGATE);
        ret_en_o = (state_i == ST_RETAIN) || (state_i == ST_CUT) ||
                   (state_i == ST_ASLEEP) || (state_i == ST_RESTORE);
        sw_en_o  = !((state_i == ST_CUT) || (state_i == ST_ASLEEP));
        unique case (state_i)
            ST_RUN:                         mode_o = MODE_RUN;
            ST_GATE, ST_RETAIN, ST_CUT:     mode_o = MODE_DOWN;
            ST_ASLEEP:                      mode_o = MODE_ASLEEP;
            default:                        mode_o = MODE_UP;
        endcase
        busy_o = (mode_o == MODE_DOWN) || (mode_o == MODE_UP);
    end

endmodule

// File: rtl/rpg_seq.sv
module rpg_seq
    import rpg_pkg::*;
#(
    parameter int SETTLE_CYC = 2,
    parameter int PG_TIMEOUT = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sleep_req_i,
    input  logic       wake_req_i,
    input  logic       pwr_good_i,
    output logic       clk_en_o,
    output logic       ret_en_o,
    output logic       pwr_sw_en_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] mode_o,
    output logic       pg_err_o
);
    localparam rpg_regs_t REGS_RST = '{st: ST_RUN, wake_pend: 1'b0, pg_err: 1'b0, done: 1'b0};

    rpg_regs_t r_d, r_q;
    logic      step_change;
    logic      settle_exp;
    logic      tmo_exp;
    rpg_mode_e mode_w;

    assign step_change = (r_d.st != r_q.st);

    rpg_step_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(step_change),
        .expired_o(settle_exp)
    );

    rpg_step_timer #(.LIMIT(PG_TIMEOUT)) u_pg_window (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(step_change),
        .expired_o(tmo_exp)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_RUN: begin
                if (sleep_req_i) begin
                    r_d.st     = ST_GATE;
                    r_d.pg_err = 1'b0;
                end
            end
            ST_GATE: begin
                if (wake_req_i) r_d.wake_pend = 1'b1;
                if (settle_exp) r_d.st = ST_RETAIN;
            end
            ST_RETAIN: begin
                if (wake_req_i) r_d.wake_pend = 1'b1;
                if (settle_exp) r_d.st = ST_CUT;
            end
            ST_CUT: begin
                if (wake_req_i) r_d.wake_pend = 1'b1;
                if (settle_exp) begin
                    r_d.st   = ST_ASLEEP;
                    r_d.done = 1'b1;
                end
            end
            ST_ASLEEP: begin
                if (wake_req_i || r_q.wake_pend) begin
                    r_d.st        = ST_RESTORE;
                    r_d.wake_pend = 1'b0;
                    r_d.pg_err    = 1'b0;
                end
            end
            ST_RESTORE: begin
                if (settle_exp && pwr_good_i) begin
                    r_d.st = ST_RELEASE;
                end else if (tmo_exp) begin
                    r_d.st     = ST_ASLEEP;
                    r_d.pg_err = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (settle_exp) r_d.st = ST_UNGATE;
            end
            default: begin
                if (settle_exp) begin
                    r_d.st   = ST_RUN;
                    r_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    rpg_ctrl_decode u_decode (
        .state_i (r_q.st),
        .clk_en_o(clk_en_o),
        .ret_en_o(ret_en_o),
        .sw_en_o (pwr_sw_en_o),
        .busy_o  (busy_o),
        .mode_o  (mode_w)
    );

    assign mode_o   = mode_w;
    assign done_o   = r_q.done;
    assign pg_err_o = r_q.pg_err;

    AST_NO_CLK_IN_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_en_o |-> !clk_en_o); // R4

    AST_SUPPLY_OFF_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_sw_en_o |-> (ret_en_o && !clk_en_o)); // R5

    AST_ONE_CTRL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({clk_en_o != $past(clk_en_o), ret_en_o != $past(ret_en_o),
                    pwr_sw_en_o != $past(pwr_sw_en_o)}) <= 1); // R6

    AST_RELEASE_AFTER_PGOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(ret_en_o) && $past(mode_o) == 2'd3) |-> ($past(pwr_good_i) && pwr_sw_en_o)); // R3

    AST_ERR_LEAVES_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pg_err_o) |-> (mode_o == 2'd2 && ret_en_o && !pwr_sw_en_o && !done_o)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R10

    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o); // R10

endmodule

// File: tb/rpg_seq_tb_top.sv
module rpg_seq_tb_top;
    localparam int SETTLE = 2;
    localparam int TMO    = 16;

    localparam int P_RUN = 0, P_GATE = 1, P_RET = 2, P_CUT = 3,
                   P_SLEEP = 4, P_PWR = 5, P_REL = 6, P_UNG = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake_req = 1'b0;
    logic       pgood = 1'b0;
    logic       clk_en, ret_en, sw_en, busy, done, pg_err;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int m_st = P_RUN;
    int m_cnt = 0;
    bit m_pend = 0;
    bit m_err = 0;
    bit m_done = 0;

    always #4 clk = ~clk;

    rpg_seq #(.SETTLE_CYC(SETTLE), .PG_TIMEOUT(TMO)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sleep_req_i(sleep_req),
        .wake_req_i (wake_req),
        .pwr_good_i (pgood),
        .clk_en_o   (clk_en),
        .ret_en_o   (ret_en),
        .pwr_sw_en_o(sw_en),
        .busy_o     (busy),
        .done_o     (done),
        .mode_o     (mode),
        .pg_err_o   (pg_err)
    );

    function automatic int exp_mode(int st);
        if (st == P_RUN) return 0;
        if (st <= P_CUT) return 1;
        if (st == P_SLEEP) return 2;
        return 3;
    endfunction

    function automatic bit exp_clk(int st);
        return (st == P_RUN) || (st == P_UNG);
    endfunction

    function automatic bit exp_ret(int st);
        return (st >= P_RET) && (st <= P_PWR);
    endfunction

    function automatic bit exp_sw(int st);
        return !((st == P_CUT) || (st == P_SLEEP));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model, stepped on each rising edge from the requirements
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = P_RUN; m_cnt = 0; m_pend = 0; m_err = 0; m_done = 0;
        end else begin
            int  nx;
            bit  s_ok, t_ok, dn;
            nx   = m_st;
            dn   = 0;
            s_ok = (m_cnt >= SETTLE - 1);
            t_ok = (m_cnt >= TMO - 1);
            case (m_st)
                P_RUN:   if (sleep_req) begin nx = P_GATE; m_err = 0; end
                P_GATE, P_RET, P_CUT: begin
                    if (wake_req) m_pend = 1;
                    if (s_ok) begin
                        nx = m_st + 1;
                        if (m_st == P_CUT) dn = 1;
                    end
                end
                P_SLEEP: if (wake_req || m_pend) begin nx = P_PWR; m_pend = 0; m_err = 0; end
                P_PWR: begin
                    if (s_ok && pgood) nx = P_REL;
                    else if (t_ok) begin nx = P_SLEEP; m_err = 1; end
                end
                P_REL:   if (s_ok) nx = P_UNG;
                default: if (s_ok) begin nx = P_RUN; dn = 1; end
            endcase
            m_cnt  = (nx != m_st) ? 0 : m_cnt + 1;
            m_st   = nx;
            m_done = dn;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cycles++;
        chk(clk_en == exp_clk(m_st), "R2 R3 clk_en", int'(clk_en), int'(exp_clk(m_st)));
        chk(ret_en == exp_ret(m_st), "R2 R3 ret_en", int'(ret_en), int'(exp_ret(m_st)));
        chk(sw_en == exp_sw(m_st), "R2 R3 sw_en", int'(sw_en), int'(exp_sw(m_st)));
        chk(int'(mode) == exp_mode(m_st), "R11 mode", int'(mode), exp_mode(m_st));
        chk(busy == (exp_mode(m_st) == 1 || exp_mode(m_st) == 3), "R10 busy", int'(busy),
            int'(exp_mode(m_st) == 1 || exp_mode(m_st) == 3));
        chk(done == m_done, "R10 done", int'(done), int'(m_done));
        chk(pg_err == m_err, "R7 pg_err", int'(pg_err), int'(m_err));
        chk(!(clk_en && ret_en), "R4 clk_en with ret_en", int'(clk_en && ret_en), 0);
        chk(sw_en || (ret_en && !clk_en), "R5 supply off unsafe", int'(sw_en), 1);
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    endtask

    task automatic wait_mode(input int m);
        for (int i = 0; i < 200 && int'(mode) != m; i++) @(negedge clk);
    endtask

    initial begin
        // R1: reset values, during and after reset
        tick(3);
        chk(clk_en && !ret_en && sw_en && !busy && !done && !pg_err && mode == 2'd0,
            "R1 reset state", int'({clk_en, ret_en, sw_en, busy, done, pg_err}), 6'b101000);
        rst_n = 1'b1;
        tick(2);
        chk(clk_en && !ret_en && sw_en && mode == 2'd0, "R1 after reset",
            int'({clk_en, ret_en, sw_en}), 3'b101);

        // R9: wake while running is ignored
        pulse_wake();
        chk(mode == 2'd0 && clk_en, "R9 wake in run ignored", int'(mode), 0);

        // R2: power-down ordering
        pulse_sleep();
        chk(!clk_en && !ret_en && sw_en, "R2 clock gated first", int'({clk_en, ret_en, sw_en}), 3'b001);
        tick(SETTLE);
        chk(!clk_en && ret_en && sw_en, "R2 retention second", int'({clk_en, ret_en, sw_en}), 3'b011);
        tick(SETTLE);
        chk(!clk_en && ret_en && !sw_en, "R2 supply cut third", int'({clk_en, ret_en, sw_en}), 3'b010);
        tick(SETTLE);
        chk(mode == 2'd2 && done, "R2 asleep with done", int'(mode), 2);

        // R9: sleep while asleep is ignored
        pulse_sleep();
        chk(mode == 2'd2 && !busy, "R9 sleep in asleep ignored", int'(mode), 2);

        // R3: wake ordering, power-good late
        pgood = 1'b0;
        pulse_wake();
        chk(sw_en && ret_en && !clk_en, "R3 supply restored first", int'({clk_en, ret_en, sw_en}), 3'b011);
        tick(5);
        chk(ret_en, "R3 retention held without power-good", int'(ret_en), 1);
        pgood = 1'b1;
        tick(1);
        chk(!ret_en && !clk_en, "R3 retention released", int'(ret_en), 0);
        tick(SETTLE);
        chk(clk_en, "R3 clock last", int'(clk_en), 1);
        tick(SETTLE);
        chk(mode == 2'd0 && done, "R3 running with done", int'(mode), 0);

        // R7: power-good timeout
        pulse_sleep();
        wait_mode(2);
        pgood = 1'b0;
        pulse_wake();
        tick(TMO);
        chk(pg_err && mode == 2'd2 && !sw_en && ret_en && !done, "R7 timeout",
            int'({pg_err, mode}), 3'b110);
        pgood = 1'b1;
        pulse_wake();
        chk(!pg_err && mode == 2'd3, "R7 error cleared on wake", int'(pg_err), 0);
        wait_mode(0);

        // R8: wake during power-down is held
        pulse_sleep();
        pulse_wake();
        wait_mode(2);
        chk(mode == 2'd2, "R8 reached asleep", int'(mode), 2);
        tick(1);
        chk(mode == 2'd3 && sw_en, "R8 held wake served", int'(mode), 3);
        wait_mode(0);

        // Constrained random segments with a power-good bias
        void'($urandom(32'h5eed_1234));
        for (int seg = 0; seg < 20; seg++) begin
            int bias;
            bias = $urandom_range(0, 3);
            for (int c = 0; c < 150; c++) begin
                sleep_req = ($urandom_range(0, 7) == 0);
                wake_req  = ($urandom_range(0, 7) == 0);
                pgood     = (bias == 0) ? 1'b0 : ($urandom_range(0, 3) < bias);
                @(negedge clk);
            end
        end
        sleep_req = 1'b0;
        wake_req  = 1'b0;
        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule